// File: doc/BRIEF.md
# Highest-First Round-Robin Unit Selector

This block decides which unit of a multi-unit execution resource is handed out next. The units are identified by one-hot bits in a mask of up to `W` bits (16 by default). A rotating pending mask always offers its highest set bit as the current choice. Each select request consumes that bit. When the pending mask runs dry, it is refilled from the size mask, which is the full set of units the resource owns.

A caller that binds work to one particular unit can strike that unit from the current round with a static-remove request. If the unit has already been handed out this round, the strike is remembered instead. It is then applied once, at the next refill. Separately, the block tracks a ready mask with per-unit take and give-back requests. It reports any misuse (taking a unit that is not ready, returning one that is already ready or does not exist, selecting from an empty pending mask) on a one-cycle error flag.

The size mask is derived from static configuration. In group mode, the descriptor mask without its highest set bit is the set of member units, because that top bit names the group itself. In plain mode, the configured unit count `N` gives the low `N` bits. The configuration is expected to be stable and is captured by reset.

Top module: `unit_sel_top`

## Requirements
- R1: After reset, `readyMask` equals the size mask, `selUnit` is the highest bit of the size mask, and `errFlag` is 0.
- R2: `selUnit` is always the highest set bit of the current pending mask, or 0 when the pending mask is empty. Back-to-back selects therefore visit units from the highest bit down (size 0b111 gives 0b100, 0b010, 0b001).
- R3: With `cfgIsGroup`=1, the size mask is `cfgMask` with its highest set bit cleared. With `cfgIsGroup`=0, it is the low `cfgNumUnits` bits set, and all bits when `cfgNumUnits` ≥ `W`.
- R4: A select clears the offered bit from the pending mask at the clock edge. If the pending mask becomes empty, it is refilled the same edge with the size mask minus the remembered-removed bits.
- R5: A static remove whose one-hot `remId` bit is still pending clears that bit, so the unit is skipped for the rest of the round.
- R6: A static remove whose bit is not pending records the bit. At the next refill, that bit is left out of the refilled mask and the record is then cleared, so the refill after that is the full size mask.
- R7: A legal take (`useReq` with a ready one-hot `useId`) clears that ready bit at the edge. A legal give-back (`relReq` with a one-hot `relId` that is not ready and lies inside the size mask) sets it.
- R8: An illegal take or give-back leaves `readyMask` unchanged and raises `errFlag` for the one cycle after the request.
- R9: A select while the pending mask is empty changes nothing and raises `errFlag` for the one cycle after the request.
- R10: When select and static remove arrive in the same cycle, the select is applied first. The remove is then judged against the mask that remains after the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; captures the configuration |
| cfgIsGroup | input | 1 | 1: group descriptor mode, 0: plain unit-count mode |
| cfgMask | input | W | Group descriptor mask (group mode) |
| cfgNumUnits | input | $clog2(W+1) | Unit count (plain mode) |
| selReq | input | 1 | Consume the currently offered unit |
| remReq | input | 1 | Static-remove request |
| remId | input | W | One-hot unit for static remove |
| useReq | input | 1 | Take-unit request |
| useId | input | W | One-hot unit to take |
| relReq | input | 1 | Give-back request |
| relId | input | W | One-hot unit to give back |
| selUnit | output | W | One-hot offered unit (0 if none) |
| readyMask | output | W | Units currently ready |
| errFlag | output | 1 | Misuse seen in the previous cycle |

## Verification
`selUnit` depends only on state, so it shows the effect of a select or remove one clock after the request, with no extra latency. `readyMask` and `errFlag` are registers, and they also change at the edge that consumes the request. The bench drives each request just after a falling edge and compares every output at the following falling edge against its own model, so each result is read exactly one edge after its stimulus. The bench also steps through directed sequences for refill, removal and same-cycle ordering, where the expected order of offered units is written out by hand.

// File: rtl/unit_sel_pkg.sv
package unit_sel_pkg;
  typedef struct packed {
    logic selFire;   // select with a non-empty pending mask
    logic remHit;    // remove of a still-pending bit
    logic remMiss;   // remove of a bit already gone this round
    logic useFire;   // legal take
    logic relFire;   // legal give-back
    logic errPulse;  // any misuse this cycle
  } selStrobes_t;
endpackage

// File: rtl/unit_sel_topbit.sv
module unit_sel_topbit #(
  parameter int W = 16
) (
  input  logic [W-1:0] vecIn,
  output logic [W-1:0] topOut
);
  always_comb begin
    logic found;
    found  = 1'b0;
    topOut = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vecIn[i]) begin
        topOut[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/unit_sel_ctrl.sv
module unit_sel_ctrl
  import unit_sel_pkg::*;
#(
  parameter int W    = 16,
  parameter int NUMW = $clog2(W + 1)
) (
  input  logic            cfgIsGroup,
  input  logic [W-1:0]    cfgMask,
  input  logic [NUMW-1:0] cfgNumUnits,
  input  logic            selReq,
  input  logic            remReq,
  input  logic [W-1:0]    remId,
  input  logic            useReq,
  input  logic [W-1:0]    useId,
  input  logic            relReq,
  input  logic [W-1:0]    relId,
  input  logic [W-1:0]    nextMask,
  input  logic [W-1:0]    selUnit,
  input  logic [W-1:0]    readyMask,
  output logic [W-1:0]    sizeMask,
  output selStrobes_t     strobes
);
  logic [W-1:0] cfgTop;
  logic [W-1:0] plainMask;
  logic [W-1:0] afterSel;
  logic         useOk;
  logic         relOk;
  logic         selErr;

  unit_sel_topbit #(.W(W)) cfgTop_i (.vecIn(cfgMask), .topOut(cfgTop));

  for (genvar g = 0; g < W; g++) begin : g_plain
    assign plainMask[g] = (NUMW'(g) < cfgNumUnits);
  end

  assign sizeMask = cfgIsGroup ? (cfgMask & ~cfgTop) : plainMask;

  assign selErr   = selReq && (nextMask == '0);
  assign afterSel = (selReq && !selErr) ? (nextMask & ~selUnit) : nextMask;
  assign useOk    = (useId != '0) && ((useId & ~readyMask) == '0);
  assign relOk    = (relId != '0) && ((relId & (readyMask | ~sizeMask)) == '0);

  always_comb begin
    strobes          = '0;
    strobes.selFire  = selReq && !selErr;
    strobes.remHit   = remReq && ((remId & afterSel) != '0);
    strobes.remMiss  = remReq && ((remId & afterSel) == '0);
    strobes.useFire  = useReq && useOk;
    strobes.relFire  = relReq && relOk;
    strobes.errPulse = selErr || (useReq && !useOk) || (relReq && !relOk);
  end
endmodule

// File: rtl/unit_sel_dp.sv
module unit_sel_dp
  import unit_sel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  selStrobes_t  strobes,
  input  logic [W-1:0] sizeMask,
  input  logic [W-1:0] selUnit,
  input  logic [W-1:0] remId,
  input  logic [W-1:0] useId,
  input  logic [W-1:0] relId,
  output logic [W-1:0] nextMask,
  output logic [W-1:0] readyMask,
  output logic         errFlag
);
  logic [W-1:0] remMask;
  logic [W-1:0] m1, m2, r1;
  logic [W-1:0] nextN, remN, readyN;

  always_comb begin
    m1 = strobes.selFire ? (nextMask & ~selUnit) : nextMask;
    m2 = strobes.remHit  ? (m1 & ~remId)         : m1;
    r1 = strobes.remMiss ? (remMask | remId)     : remMask;
    nextN = m2;
    remN  = r1;
    if ((strobes.selFire || strobes.remHit || strobes.remMiss) && (m2 == '0)) begin
      nextN = sizeMask & ~r1;
      remN  = '0;
    end
    readyN = readyMask;
    if (strobes.useFire) readyN = readyN & ~useId;
    if (strobes.relFire) readyN = readyN | relId;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nextMask  <= sizeMask;
      remMask   <= '0;
      readyMask <= sizeMask;
      errFlag   <= 1'b0;
    end else begin
      nextMask  <= nextN;
      remMask   <= remN;
      readyMask <= readyN;
      errFlag   <= strobes.errPulse;
    end
  end
endmodule

// File: rtl/unit_sel_top.sv
module unit_sel_top
  import unit_sel_pkg::*;
#(
  parameter int W    = 16,
  parameter int NUMW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfgIsGroup,
  input  logic [W-1:0]    cfgMask,
  input  logic [NUMW-1:0] cfgNumUnits,
  input  logic            selReq,
  input  logic            remReq,
  input  logic [W-1:0]    remId,
  input  logic            useReq,
  input  logic [W-1:0]    useId,
  input  logic            relReq,
  input  logic [W-1:0]    relId,
  output logic [W-1:0]    selUnit,
  output logic [W-1:0]    readyMask,
  output logic            errFlag
);
  logic [W-1:0] sizeMask;
  logic [W-1:0] nextMask;
  selStrobes_t  strobes;

  unit_sel_topbit #(.W(W)) selTop_i (.vecIn(nextMask), .topOut(selUnit));

  unit_sel_ctrl #(.W(W), .NUMW(NUMW)) ctrl_i (
    .cfgIsGroup(cfgIsGroup), .cfgMask(cfgMask), .cfgNumUnits(cfgNumUnits),
    .selReq(selReq), .remReq(remReq), .remId(remId),
    .useReq(useReq), .useId(useId), .relReq(relReq), .relId(relId),
    .nextMask(nextMask), .selUnit(selUnit), .readyMask(readyMask),
    .sizeMask(sizeMask), .strobes(strobes)
  );

  unit_sel_dp #(.W(W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .sizeMask(sizeMask),
    .selUnit(selUnit), .remId(remId), .useId(useId), .relId(relId),
    .nextMask(nextMask), .readyMask(readyMask), .errFlag(errFlag)
  );
endmodule

// File: rtl/unit_sel_chk.sv
module unit_sel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         selReq,
  input logic         remReq,
  input logic         useReq,
  input logic [W-1:0] useId,
  input logic         relReq,
  input logic [W-1:0] relId,
  input logic [W-1:0] selUnit,
  input logic [W-1:0] readyMask,
  input logic         errFlag,
  input logic [W-1:0] sizeMask,
  input logic [W-1:0] nextMask
);
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(selUnit));

  p_sel_in_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (selUnit & ~sizeMask) == '0);

  p_ready_in_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (readyMask & ~sizeMask) == '0);

  p_sel_descends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    selReq && !remReq && ((nextMask & ~selUnit) != '0) |=> (selUnit < $past(selUnit)));

  p_use_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    useReq && !relReq && $onehot(useId) && ((useId & ~readyMask) == '0)
    |=> ((readyMask & $past(useId)) == '0));

  p_rel_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    relReq && !useReq && $onehot(relId) && ((relId & (readyMask | ~sizeMask)) == '0)
    |=> ((readyMask & $past(relId)) == $past(relId)));

  p_bad_use_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    useReq && ((useId & ~readyMask) != '0) |=> errFlag);

  p_bad_use_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    useReq && !relReq && ((useId & ~readyMask) != '0) |=> $stable(readyMask));

  p_empty_sel_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    selReq && (selUnit == '0) |=> errFlag);
endmodule

bind unit_sel_top unit_sel_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .selReq(selReq), .remReq(remReq),
  .useReq(useReq), .useId(useId), .relReq(relReq), .relId(relId),
  .selUnit(selUnit), .readyMask(readyMask), .errFlag(errFlag),
  .sizeMask(sizeMask), .nextMask(nextMask)
);

// File: tb/unit_sel_tb.sv
`timescale 1ns/1ps
module unit_sel_top_tb_top;
  localparam int W    = 16;
  localparam int NUMW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgIsGroup = 1'b0;
  logic [W-1:0] cfgMask = '0;
  logic [NUMW-1:0] cfgNumUnits = '0;
  logic selReq = 1'b0, remReq = 1'b0, useReq = 1'b0, relReq = 1'b0;
  logic [W-1:0] remId = '0, useId = '0, relId = '0;
  logic [W-1:0] selUnit, readyMask;
  logic errFlag;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mSize, mNext, mRem, mReady;
  logic mErr;

  always #5 clk = ~clk;

  unit_sel_top #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfgIsGroup(cfgIsGroup), .cfgMask(cfgMask),
    .cfgNumUnits(cfgNumUnits), .selReq(selReq), .remReq(remReq), .remId(remId),
    .useReq(useReq), .useId(useId), .relReq(relReq), .relId(relId),
    .selUnit(selUnit), .readyMask(readyMask), .errFlag(errFlag)
  );

  function automatic logic [W-1:0] msbOf(logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) if (v[i]) return W'(1) << i;
    return '0;
  endfunction

  function automatic logic [W-1:0] sizeOf(logic grp, logic [W-1:0] m, int n);
    logic [W-1:0] s;
    if (grp) return m & ~msbOf(m);
    s = '0;
    for (int i = 0; i < W; i++) if (i < n) s[i] = 1'b1;
    return s;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(logic grp, logic [W-1:0] m, int n);
    @(negedge clk);
    rst_n = 1'b0;
    cfgIsGroup = grp; cfgMask = m; cfgNumUnits = NUMW'(n);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mSize = sizeOf(grp, m, n);
    mNext = mSize; mRem = '0; mReady = mSize; mErr = 1'b0;
    #1;
    chk("R1 readyMask after reset", readyMask, mSize);
    chk("R1 selUnit after reset", selUnit, msbOf(mSize));
    chk("R1 errFlag after reset", W'(errFlag), '0);
  endtask

  // Drives one cycle of requests (called just after a falling edge),
  // updates the model, and compares all outputs at the next falling edge.
  task automatic cyc(logic s, logic r, logic [W-1:0] rid, logic u, logic [W-1:0] uid,
                     logic l, logic [W-1:0] lid);
    logic [W-1:0] top, m1, m2, rm, useAp, relAp;
    logic e;
    selReq = s; remReq = r; remId = rid; useReq = u; useId = uid; relReq = l; relId = lid;
    e = 1'b0;
    top = msbOf(mNext);
    m1 = mNext;
    if (s) begin
      if (mNext == '0) e = 1'b1; else m1 = mNext & ~top;
    end
    m2 = m1; rm = mRem;
    if (r) begin
      if ((m1 & rid) != '0) m2 = m1 & ~rid; else rm = mRem | rid;
    end
    if (((s && mNext != '0) || r) && m2 == '0) begin
      m2 = mSize & ~rm; rm = '0;
    end
    useAp = '0; relAp = '0;
    if (u) begin
      if (uid != '0 && (uid & ~mReady) == '0) useAp = uid; else e = 1'b1;
    end
    if (l) begin
      if (lid != '0 && (lid & (mReady | ~mSize)) == '0) relAp = lid; else e = 1'b1;
    end
    mReady = (mReady & ~useAp) | relAp;
    mNext = m2; mRem = rm; mErr = e;
    @(negedge clk);
    selReq = 1'b0; remReq = 1'b0; useReq = 1'b0; relReq = 1'b0;
    remId = '0; useId = '0; relId = '0;
    #1;
    chk("R2 selUnit vs model", selUnit, msbOf(mNext));
    chk("R7 readyMask vs model", readyMask, mReady);
    chk("R8 errFlag vs model", W'(errFlag), W'(mErr));
  endtask

  task automatic sel1();
    cyc(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic randomRun(int n);
    for (int k = 0; k < n; k++) begin
      logic s, r, u, l;
      logic [W-1:0] a, b, c;
      s = ($urandom % 2) == 0;
      r = ($urandom % 4) == 0;
      u = ($urandom % 3) == 0;
      l = ($urandom % 3) == 0;
      a = W'(1) << ($urandom % W);
      b = W'(1) << ($urandom % W);
      c = W'(1) << ($urandom % W);
      cyc(s, r, a, u, b, l, c);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // R1, R2, R4: plain resource with three units
    doReset(1'b0, '0, 3);
    sel1(); chk("R2 second offer", selUnit, 16'h0002);
    sel1(); chk("R2 third offer", selUnit, 16'h0001);
    sel1(); chk("R4 refill after empty", selUnit, 16'h0004);

    // R3: group descriptors
    doReset(1'b1, 16'h000F, 0);
    chk("R3 group size as ready", readyMask, 16'h0007);
    doReset(1'b1, 16'h80F6, 0);
    chk("R3 group top offer", selUnit, 16'h0080);
    chk("R3 group ready", readyMask, 16'h00F6);
    doReset(1'b0, '0, 16);
    chk("R3 full plain", readyMask, 16'hFFFF);

    // R5: remove still-pending unit
    doReset(1'b0, '0, 3);
    cyc(1'b0, 1'b1, 16'h0002, 1'b0, '0, 1'b0, '0);
    chk("R5 offer unchanged", selUnit, 16'h0004);
    sel1(); chk("R5 removed unit skipped", selUnit, 16'h0001);
    sel1(); chk("R5 full refill", selUnit, 16'h0004);

    // R6: remove of already-consumed unit is applied at the next refill
    doReset(1'b0, '0, 3);
    sel1(); sel1();
    cyc(1'b0, 1'b1, 16'h0004, 1'b0, '0, 1'b0, '0);
    chk("R6 pending unaffected", selUnit, 16'h0001);
    sel1(); chk("R6 refill excludes recorded unit", selUnit, 16'h0002);
    sel1(); chk("R6 next offer", selUnit, 16'h0001);
    sel1(); chk("R6 record cleared after use", selUnit, 16'h0004);

    // R10: select and remove together, select first
    doReset(1'b0, '0, 3);
    cyc(1'b1, 1'b1, 16'h0004, 1'b0, '0, 1'b0, '0);
    chk("R10 after joint request", selUnit, 16'h0002);
    sel1(); sel1();
    chk("R10 refill excludes unit", selUnit, 16'h0002);

    // R7, R8: take and give back
    doReset(1'b0, '0, 3);
    cyc(1'b0, 1'b0, '0, 1'b1, 16'h0002, 1'b0, '0);
    chk("R7 take clears bit", readyMask, 16'h0005);
    cyc(1'b0, 1'b0, '0, 1'b1, 16'h0002, 1'b0, '0);
    chk("R8 bad take flagged", W'(errFlag), 16'h0001);
    chk("R8 bad take keeps mask", readyMask, 16'h0005);
    idle(); chk("R8 flag lasts one cycle", W'(errFlag), '0);
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, 16'h0002);
    chk("R7 give-back sets bit", readyMask, 16'h0007);
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, 16'h0001);
    chk("R8 give-back of ready unit flagged", W'(errFlag), 16'h0001);
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, 16'h0010);
    chk("R8 give-back outside size flagged", W'(errFlag), 16'h0001);
    chk("R8 mask unchanged", readyMask, 16'h0007);

    // R9: empty resource
    doReset(1'b0, '0, 0);
    sel1();
    chk("R9 empty select flagged", W'(errFlag), 16'h0001);
    chk("R9 no offer", selUnit, '0);

    // Random traffic against the model
    doReset(1'b0, '0, 5);
    randomRun(600);
    doReset(1'b1, 16'h80F6, 0);
    randomRun(600);
    doReset(1'b0, '0, 16);
    randomRun(600);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule